// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Controller

This block sits beside an instruction sequencer. At every instruction boundary it decides whether to enter a handler, and for which source. Three kinds of request compete: internally raised exceptions, a non-maskable request line, and a level-sensitive maskable request line that is gated by the interrupt-enable flag. The winner is reported with a one-cycle take pulse, a source code and an 8-bit vector.

Exceptions and the non-maskable request carry their vector internally. A maskable interrupt starts an acknowledge handshake instead, and its vector arrives from outside when that handshake completes. Whenever a hardware interrupt is entered, the block asks the core to clear the enable flag. It keeps a short LIFO of the flag values that were live when each handler was entered, and on a return-from-interrupt strobe it hands back the saved value.

The non-maskable input is asynchronous. It is synchronized and edge detected, and one request can be held pending while a non-maskable handler is still active; that request is serviced after the first return.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is applied and in the first cycle after it, take_pulse, vec_valid, ack_req, ie_clear and ie_restore are 0 and vec_out is 0.
- R2: take_pulse rises only in the cycle after a cycle in which boundary was high; with no boundary, no level on the request inputs produces a take.
- R3: An exception request at a boundary wins over every other source. It gives take_src=1 and vec_out equal to the 5-bit exc_code zero-extended (so always 0..31), with vec_valid=1, no ack_req and no ie_clear.
- R4: A pending non-maskable request taken at a boundary gives take_src=2 and vec_out=2, with vec_valid=1 and ie_clear=1 in the same cycle, and no ack_req.
- R5: intr_in is taken only when intr_in and ie_flag are both high at a boundary. This gives take_src=3, ie_clear=1, vec_valid=0 and ack_req=1. ack_req stays high until ack_valid. One cycle after ack_valid, vec_valid=1 with vec_out=ack_vec, and ack_req=0.
- R6: When a non-maskable request and an enabled maskable request meet at one boundary, the non-maskable one is taken. The maskable one is taken at a later boundary only if ie_flag is high then.
- R7: While a non-maskable handler is active (from its take until the next iret_done), no further non-maskable take occurs. A request that arrives meanwhile is taken at the first boundary after iret_done.
- R8: Any number of nmi_in rising edges seen while a request is already pending yield exactly one non-maskable take.
- R9: Each take pushes the ie_flag value seen at that boundary onto a LIFO. A cycle after iret_done, ie_restore=1 and ie_restore_val shows the most recently pushed value, which is then popped. A pop from an empty LIFO shows 0.
- R10: While ack_req is high, boundary strobes are ignored and no take occurs.
- R11: nmi_in is edge sensitive: holding it high across several boundaries and returns yields a single take.
- R12: Reset clears both the pending and the active non-maskable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Asynchronous non-maskable request, rising edge |
| intr_in | input | 1 | Level-sensitive maskable request |
| ie_flag | input | 1 | Current interrupt-enable flag of the core |
| boundary | input | 1 | Instruction-boundary strobe |
| exc_req | input | 1 | Internal exception request |
| exc_code | input | 5 | Exception vector number |
| iret_done | input | 1 | Return-from-interrupt executed strobe |
| ack_valid | input | 1 | Acknowledge cycle finished, ack_vec valid |
| ack_vec | input | 8 | Vector returned by the acknowledge cycle |
| take_pulse | output | 1 | One-cycle pulse: handler entry decided |
| take_src | output | 2 | Source of the take: 1 exception, 2 non-maskable, 3 maskable |
| vec_valid | output | 1 | vec_out holds a fresh vector |
| vec_out | output | 8 | Selected vector |
| ack_req | output | 1 | Run an acknowledge cycle (held until ack_valid) |
| ie_clear | output | 1 | Command to clear the enable flag |
| ie_restore | output | 1 | Command to restore the enable flag |
| ie_restore_val | output | 1 | Value to restore into the enable flag |

## Verification
A stuck active bit shows at the ports as a missing take one cycle after the first boundary that follows a return. A lost pending bit shows the same way, at the same point. A pending bit that is not cleared when taken shows as a second, unwanted vector-2 take at the following boundary. A corrupt flag LIFO shows as a wrong ie_restore_val one cycle after each return. A stuck acknowledge state blocks every later take, which any following boundary check exposes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_EXC  = 2'd1,
      SRC_NMI  = 2'd2,
      SRC_INTR = 2'd3
   } src_e;
endpackage

// File: rtl/irq_nmi_track.sv
module irq_nmi_track #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic take_nmi,
   input  logic iret_done,
   output logic nmi_pend,
   output logic nmi_act
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_nmi_track: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic               rise;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], nmi_in};
   end

   assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   // a new edge wins over a same-cycle take; edges while pending merge
   always_ff @(posedge clk) begin
      if (!rst_n)        nmi_pend <= 1'b0;
      else if (rise)     nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         nmi_act <= 1'b0;
      else if (take_nmi)  nmi_act <= 1'b1;
      else if (iret_done) nmi_act <= 1'b0;
   end

   // R7: never taken while a handler of the same kind runs
   a_r7_no_nested_take: assert property (@(posedge clk) disable iff (!rst_n)
      take_nmi |-> (nmi_pend && !nmi_act));

   // R8: a pending request survives until taken
   a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && !take_nmi) |=> nmi_pend);
endmodule

// File: rtl/irq_ie_stack.sv
module irq_ie_stack #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_val,
   input  logic pop,
   output logic top_val
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("irq_ie_stack: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    bit_q <= 1'b0;
            else if (push) bit_q <= push_val;
            else if (pop)  bit_q <= 1'b0;
         end
         assign top_val = bit_q;
      end else begin : g_shift
         logic [DEPTH-1:0] stk_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stk_q <= '0;
            end else begin
               case ({push, pop})
                  2'b10:   stk_q <= {stk_q[DEPTH-2:0], push_val};
                  2'b01:   stk_q <= {1'b0, stk_q[DEPTH-1:1]};
                  2'b11:   stk_q[0] <= push_val;
                  default: stk_q <= stk_q;
               endcase
            end
         end
         assign top_val = stk_q[0];
      end
   endgenerate

   // R9: the latest pushed value is on top
   a_r9_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top_val == $past(push_val)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int EXC_W       = 5,
   parameter int NMI_VEC     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int NEST_DEPTH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_in,
   input  logic             intr_in,
   input  logic             ie_flag,
   input  logic             boundary,
   input  logic             exc_req,
   input  logic [EXC_W-1:0] exc_code,
   input  logic             iret_done,
   input  logic             ack_valid,
   input  logic [VEC_W-1:0] ack_vec,
   output logic             take_pulse,
   output logic [1:0]       take_src,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_out,
   output logic             ack_req,
   output logic             ie_clear,
   output logic             ie_restore,
   output logic             ie_restore_val
);
   localparam int                 PAD_W   = VEC_W - EXC_W;
   localparam logic [VEC_W-1:0]   NMI_V   = VEC_W'(NMI_VEC);

   generate
      if (EXC_W >= VEC_W) begin : g_bad_exc
         $error("irq_arbiter: EXC_W must be narrower than VEC_W");
      end
      if (NMI_VEC >= (1 << VEC_W)) begin : g_bad_nmi
         $error("irq_arbiter: NMI_VEC does not fit in VEC_W");
      end
   endgenerate

   logic nmi_pend, nmi_act, top_val;
   logic ack_busy, go, take;
   src_e sel;

   assign go = boundary & ~ack_busy;

   always_comb begin
      if (exc_req)                  sel = SRC_EXC;
      else if (nmi_pend && !nmi_act) sel = SRC_NMI;
      else if (intr_in && ie_flag)   sel = SRC_INTR;
      else                           sel = SRC_NONE;
   end

   assign take = go && (sel != SRC_NONE);

   irq_nmi_track #(.SYNC_STAGES(SYNC_STAGES)) nmi_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_in    (nmi_in),
      .take_nmi  (take && (sel == SRC_NMI)),
      .iret_done (iret_done),
      .nmi_pend  (nmi_pend),
      .nmi_act   (nmi_act)
   );

   irq_ie_stack #(.DEPTH(NEST_DEPTH)) stk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_val (ie_flag),
      .pop      (iret_done),
      .top_val  (top_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_pulse     <= 1'b0;
         take_src       <= SRC_NONE;
         vec_valid      <= 1'b0;
         vec_out        <= '0;
         ack_busy       <= 1'b0;
         ie_clear       <= 1'b0;
         ie_restore     <= 1'b0;
         ie_restore_val <= 1'b0;
      end else begin
         take_pulse     <= take;
         take_src       <= take ? sel : SRC_NONE;
         ie_clear       <= take && (sel == SRC_NMI || sel == SRC_INTR);
         ie_restore     <= iret_done;
         ie_restore_val <= iret_done ? top_val : 1'b0;
         vec_valid      <= 1'b0;
         if (take && sel == SRC_EXC) begin
            vec_out   <= {{PAD_W{1'b0}}, exc_code};
            vec_valid <= 1'b1;
         end else if (take && sel == SRC_NMI) begin
            vec_out   <= NMI_V;
            vec_valid <= 1'b1;
         end else if (ack_busy && ack_valid) begin
            vec_out   <= ack_vec;
            vec_valid <= 1'b1;
         end
         if (take && sel == SRC_INTR) ack_busy <= 1'b1;
         else if (ack_valid)          ack_busy <= 1'b0;
      end
   end

   assign ack_req = ack_busy;

   // R2: a take follows a boundary by one cycle
   a_r2_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      take_pulse |-> $past(boundary));

   // R3: exception entry never asks for acknowledge or flag clear
   a_r3_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (take_pulse && take_src == SRC_EXC) |-> (!ie_clear && !ack_req && vec_out < VEC_W'(1 << EXC_W)));

   // R4: non-maskable entry carries its fixed vector
   a_r4_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (take_pulse && take_src == SRC_NMI) |-> (vec_out == NMI_V && vec_valid && ie_clear && !ack_req));

   // R5: acknowledge request holds until answered
   a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !ack_valid) |=> ack_req);

   // R10: no take while acknowledge is outstanding
   a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_req) |-> !take_pulse);
endmodule

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi_in = 1'b0, intr_in = 1'b0, ie_flag = 1'b0, boundary = 1'b0;
   logic       exc_req = 1'b0, iret_done = 1'b0, ack_valid = 1'b0;
   logic [4:0] exc_code = '0;
   logic [7:0] ack_vec = '0;
   logic       take_pulse, vec_valid, ack_req, ie_clear, ie_restore, ie_restore_val;
   logic [1:0] take_src;
   logic [7:0] vec_out;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .intr_in(intr_in),
      .ie_flag(ie_flag), .boundary(boundary), .exc_req(exc_req),
      .exc_code(exc_code), .iret_done(iret_done), .ack_valid(ack_valid),
      .ack_vec(ack_vec), .take_pulse(take_pulse), .take_src(take_src),
      .vec_valid(vec_valid), .vec_out(vec_out), .ack_req(ack_req),
      .ie_clear(ie_clear), .ie_restore(ie_restore), .ie_restore_val(ie_restore_val)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; nmi_in = 0; intr_in = 0; ie_flag = 0; boundary = 0;
      exc_req = 0; iret_done = 0; ack_valid = 0;
      idle(3);
      rst_n = 1'b1;
   endtask

   // drive a boundary for one cycle; outputs are sampled one cycle later
   task automatic bnd();
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
   endtask

   task automatic ret();
      iret_done = 1'b1;
      @(negedge clk);
      iret_done = 1'b0;
   endtask

   task automatic nmi_edge();
      nmi_in = 1'b1; idle(3);
      nmi_in = 1'b0; idle(3);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "take_pulse", take_pulse, 0);
      chk("R1", "vec_valid", vec_valid, 0);
      chk("R1", "ack_req", ack_req, 0);
      chk("R1", "ie_clear", ie_clear, 0);
      chk("R1", "vec_out", vec_out, 0);
      chk("R1", "ie_restore", ie_restore, 0);
   endtask

   task automatic t_no_boundary();
      int seen = 0;
      do_reset();
      intr_in = 1; ie_flag = 1; exc_req = 1; exc_code = 5'd4;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (take_pulse) seen++;
      end
      chk("R2", "takes without boundary", seen, 0);
      intr_in = 0; exc_req = 0;
   endtask

   task automatic t_exc();
      do_reset();
      intr_in = 1; ie_flag = 1; exc_req = 1; exc_code = 5'd13;
      bnd();
      exc_req = 0; intr_in = 0;
      chk("R3", "take_pulse", take_pulse, 1);
      chk("R3", "take_src", take_src, 1);
      chk("R3", "vec_out", vec_out, 13);
      chk("R3", "vec_valid", vec_valid, 1);
      chk("R3", "ie_clear", ie_clear, 0);
      chk("R3", "ack_req", ack_req, 0);
      exc_req = 1; exc_code = 5'd31;
      bnd();
      exc_req = 0;
      chk("R3", "vec_out max code", vec_out, 31);
   endtask

   task automatic t_nmi();
      do_reset();
      nmi_in = 1; idle(4);
      bnd();
      chk("R4", "take_src", take_src, 2);
      chk("R4", "vec_out", vec_out, 2);
      chk("R4", "ie_clear", ie_clear, 1);
      chk("R4", "ack_req", ack_req, 0);
      ret(); idle(1);
      bnd();
      chk("R11", "held level retakes", take_pulse, 0);
      nmi_in = 0; idle(3);
   endtask

   task automatic t_intr();
      do_reset();
      intr_in = 1; ie_flag = 0;
      bnd();
      chk("R5", "take with flag low", take_pulse, 0);
      ie_flag = 1;
      bnd();
      ie_flag = 0; intr_in = 0;
      chk("R5", "take_src", take_src, 3);
      chk("R5", "ack_req", ack_req, 1);
      chk("R5", "ie_clear", ie_clear, 1);
      chk("R5", "vec_valid early", vec_valid, 0);
      exc_req = 1; exc_code = 5'd6;
      bnd();
      exc_req = 0;
      chk("R10", "take while ack busy", take_pulse, 0);
      chk("R5", "ack_req held", ack_req, 1);
      ack_valid = 1; ack_vec = 8'h47;
      @(negedge clk);
      ack_valid = 0;
      chk("R5", "vec_valid", vec_valid, 1);
      chk("R5", "vec_out", vec_out, 8'h47);
      chk("R5", "ack_req dropped", ack_req, 0);
   endtask

   task automatic t_nmi_vs_intr();
      do_reset();
      nmi_edge();
      intr_in = 1; ie_flag = 1;
      bnd();
      chk("R6", "take_src", take_src, 2);
      ie_flag = 0;
      bnd();
      chk("R6", "intr with flag cleared", take_pulse, 0);
      ie_flag = 1;
      bnd();
      chk("R6", "intr after enable", take_src, 3);
      intr_in = 0;
      ack_valid = 1; @(negedge clk); ack_valid = 0;
   endtask

   task automatic t_nmi_nest();
      do_reset();
      nmi_edge();
      bnd();
      chk("R7", "first take", take_src, 2);
      nmi_edge(); nmi_edge();
      bnd();
      chk("R7", "take while active", take_pulse, 0);
      ret();
      bnd();
      chk("R7", "pending after return", take_src, 2);
      ret();
      bnd();
      chk("R8", "merged edges extra take", take_pulse, 0);
   endtask

   task automatic t_restore();
      do_reset();
      ie_flag = 1; intr_in = 1;
      bnd();
      intr_in = 0;
      ack_valid = 1; @(negedge clk); ack_valid = 0;
      ie_flag = 0; exc_req = 1; exc_code = 5'd0;
      bnd();
      exc_req = 0;
      ret();
      chk("R9", "restore pulse", ie_restore, 1);
      chk("R9", "restore inner", ie_restore_val, 0);
      ret();
      chk("R9", "restore outer", ie_restore_val, 1);
      ret();
      chk("R9", "restore empty", ie_restore_val, 0);
   endtask

   task automatic t_reset_clears();
      do_reset();
      nmi_edge();
      bnd();
      nmi_edge();
      do_reset();
      bnd();
      chk("R12", "take after reset", take_pulse, 0);
      ret();
      bnd();
      chk("R12", "pending cleared", take_pulse, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
         finish_run();
      end
   end

   initial begin
      t_reset();
      t_no_boundary();
      t_exc();
      t_nmi();
      t_intr();
      t_nmi_vs_intr();
      t_nmi_nest();
      t_restore();
      t_reset_clears();
      idle(2);
      finish_run();
   end
endmodule